// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a small finite impulse response filter that forms its dot product without any multiplier. The taps carry constant unsigned coefficients fixed by a parameter. Once per processing frame a parallel input word is captured into a tap delay line. The block then walks the stored samples one bit position per clock, least significant bit first. In each clock the chosen bit of every tap forms an address into a table of coefficient partial sums built at elaboration. That table value, shifted by the current bit position, is added into a wide accumulator.

A frame lasts W clocks for a W-bit word, so the filter delivers one result every W clocks. The result is the low W bits of the exact sum, together with a one-cycle valid strobe and a sticky overflow flag. The overflow flag records that some result did not fit in W bits. The filter is used where a sample arrives at most once every W clocks and area matters more than throughput. The tap count must be at least 2 and W at least 2.

The controller has three states. ST_LOAD shifts the delay line, captures the new sample, clears the accumulator and processes bit 0. ST_ACCUM processes bits 1 to W-2. ST_LAST processes bit W-1 and registers the result. The transitions are ST_LOAD to ST_ACCUM, or to ST_LAST directly when W is 2. ST_ACCUM stays in ST_ACCUM until bit W-2 is done, then moves to ST_LAST. ST_LAST always returns to ST_LOAD. Reset enters ST_LOAD.

Top module: `da_fir_serial`

## Requirements
- R1: While reset is held and until the first frame completes, result_o is 0, valid_o is 0 and ovf_o is 0.
- R2: A frame is W rising edges. The sample on data_in is taken only at the first edge of each frame: the first edge with reset released, then every W edges. Values on data_in at any other edge have no effect on any later result.
- R3: valid_o is 1 for exactly one cycle per frame. It rises after the W-th edge of a frame and is 0 in all other cycles.
- R4: When valid_o is 1, result_o is the low W bits of the sum over taps i of coef(i)·tap(i). Coefficient i sits at bits [i·CW +: CW] of COEFS. tap(0) is the sample taken in the frame just completed, and tap(i) is the sample taken i frames earlier.
- R5: result_o holds its value in every cycle in which valid_o is 0.
- R6: ovf_o becomes 1 on the same edge as the valid_o pulse whose full sum is 2^W or more. A sum of exactly 2^W-1 does not set it.
- R7: Once set, ovf_o stays 1 until reset.
- R8: Reset clears the delay line. A tap not yet written since reset contributes zero to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | W | Unsigned sample, captured at the first edge of each frame |
| result_o | output | W | Low W bits of the filter sum, held between frames |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| ovf_o | output | 1 | Sticky flag set when a sum exceeded W bits |

## Verification
A wrong frame counter or state register shifts or multiplies the valid strobe. The next boundary that should carry a pulse exposes it, within W cycles. A corrupted tap, table entry or accumulator bit surfaces in result_o at the end of the frame that uses it. For a tap, that holds for up to NTAPS frames while the sample travels the delay line. Overflow errors appear at the first frame whose true sum crosses 2^W, or as soon as the flag drops before reset.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    // Controller states of the bit-serial frame sequencer
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,   // capture sample, clear accumulator, bit 0
        ST_ACCUM = 2'd1,   // middle bit positions
        ST_LAST  = 2'd2    // final bit position, register result
    } da_state_e;

endpackage

// File: rtl/da_tap_line.sv
module da_tap_line #(
    parameter int NTAPS = 4,
    parameter int W     = 8,
    parameter int BW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     din,
    input  logic [BW-1:0]    bsel,
    output logic [NTAPS-1:0] slice
);

    logic [W-1:0] taps_q [NTAPS];
    logic [W-1:0] view   [NTAPS];

    // During a load cycle the slice is taken from the line as it will be
    // after the shift, so bit 0 can be processed in the same cycle.
    always_comb begin
        view[0] = load ? din : taps_q[0];
        for (int i = 1; i < NTAPS; i++) begin
            view[i] = load ? taps_q[i-1] : taps_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAPS; i++) begin
                taps_q[i] <= '0;
            end
        end else if (load) begin
            taps_q[0] <= din;
            for (int i = 1; i < NTAPS; i++) begin
                taps_q[i] <= taps_q[i-1];
            end
        end
    end

    generate
        for (genvar g = 0; g < NTAPS; g++) begin : g_slice
            assign slice[g] = view[g][bsel];
        end
    endgenerate

endmodule

// File: rtl/da_psum_rom.sv
module da_psum_rom #(
    parameter int                    NTAPS = 4,
    parameter int                    CW    = 8,
    parameter int                    TW    = 11,
    parameter logic [NTAPS*CW-1:0]   COEFS = '0
) (
    input  logic [NTAPS-1:0] addr,
    output logic [TW-1:0]    psum
);

    localparam int NENT = 1 << NTAPS;

    function automatic logic [TW-1:0] entry_value(input int k);
        logic [TW-1:0] s;
        s = '0;
        for (int i = 0; i < NTAPS; i++) begin
            if (((k >> i) & 1) == 1) begin
                s = s + TW'(COEFS[i*CW +: CW]);
            end
        end
        return s;
    endfunction

    logic [TW-1:0] tbl [NENT];

    generate
        for (genvar k = 0; k < NENT; k++) begin : g_entry
            localparam logic [TW-1:0] VAL = entry_value(k);
            assign tbl[k] = VAL;
        end
    endgenerate

    assign psum = tbl[addr];

endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc #(
    parameter int TW = 11,
    parameter int AW = 19,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [TW-1:0] psum,
    input  logic [BW-1:0] bsel,
    output logic [AW-1:0] sum_next
);

    logic [AW-1:0] acc_q;
    logic [AW-1:0] addend;

    always_comb begin
        addend   = AW'(psum) << bsel;
        sum_next = (clear ? '0 : acc_q) + addend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum_next;
        end
    end

endmodule

// File: rtl/da_fir_serial.sv
module da_fir_serial
    import da_fir_pkg::*;
#(
    parameter int                  NTAPS = 4,
    parameter int                  W     = 8,
    parameter int                  CW    = 8,
    parameter logic [NTAPS*CW-1:0] COEFS = {8'd1, 8'd0, 8'd0, 8'd1}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] result_o,
    output logic         valid_o,
    output logic         ovf_o
);

    localparam int BW = $clog2(W);
    localparam int TW = CW + $clog2(NTAPS + 1);
    localparam int AW = W + TW;

    da_state_e      state_q, state_d;
    logic [BW-1:0]  cnt_q;
    logic           load;
    logic [NTAPS-1:0] slice;
    logic [TW-1:0]  psum;
    logic [AW-1:0]  sum_next;
    logic [W-1:0]   result_q;
    logic           valid_q;
    logic           ovf_q;

    assign load = (state_q == ST_LOAD);

    // Next-state logic
    always_comb begin
        state_d = ST_LOAD;
        unique case (state_q)
            ST_LOAD:  state_d = (W == 2) ? ST_LAST : ST_ACCUM;
            ST_ACCUM: state_d = (cnt_q == BW'(W - 2)) ? ST_LAST : ST_ACCUM;
            ST_LAST:  state_d = ST_LOAD;
            default:  state_d = ST_LOAD;
        endcase
    end

    // State register and bit-position counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            valid_q  <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            valid_q <= (state_q == ST_LAST);
            if (state_q == ST_LAST) begin
                result_q <= sum_next[W-1:0];
                ovf_q    <= ovf_q | (|sum_next[AW-1:W]);
            end
        end
    end

    da_tap_line #(
        .NTAPS(NTAPS),
        .W    (W),
        .BW   (BW)
    ) u_taps (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .din  (data_in),
        .bsel (cnt_q),
        .slice(slice)
    );

    da_psum_rom #(
        .NTAPS(NTAPS),
        .CW   (CW),
        .TW   (TW),
        .COEFS(COEFS)
    ) u_rom (
        .addr(slice),
        .psum(psum)
    );

    da_shift_acc #(
        .TW(TW),
        .AW(AW),
        .BW(BW)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .psum    (psum),
        .bsel    (cnt_q),
        .sum_next(sum_next)
    );

    assign result_o = result_q;
    assign valid_o  = valid_q;
    assign ovf_o    = ovf_q;

endmodule

// File: rtl/da_fir_serial_chk.sv
module da_fir_serial_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid,
    input logic [W-1:0] result,
    input logic         ovf
);

    localparam int PW = $clog2(W);

    logic [PW-1:0] ph_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= '0;
            done_q <= 1'b0;
        end else begin
            ph_q <= (ph_q == PW'(W - 1)) ? '0 : ph_q + 1'b1;
            if (ph_q == PW'(W - 1)) begin
                done_q <= 1'b1;
            end
        end
    end

    a_r1_quiet_first_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> (!valid && result == '0 && !ovf));

    a_r3_valid_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (done_q && ph_q == '0));

    a_r3_valid_due: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && ph_q == '0) |-> valid);

    a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(result));

    a_r6_ovf_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> valid);

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

endmodule

bind da_fir_serial da_fir_serial_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (valid_o),
    .result(result_o),
    .ovf   (ovf_o)
);

// File: tb/tb_da_fir_serial.sv
module tb_da_fir_serial;

    localparam int CLK_PERIOD = 10;
    localparam int NTAPS = 4;
    localparam int W     = 8;
    localparam int CW    = 8;
    localparam logic [NTAPS*CW-1:0] COEFS = {8'd1, 8'd0, 8'd0, 8'd1};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] result_o;
    logic         valid_o;
    logic         ovf_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    string sect = "R8";

    // Behavioural reference model
    int m_tap [$];
    int m_ph = 0;
    int e_res = 0;
    int e_val = 0;
    int e_ovf = 0;
    int frames = 0;

    da_fir_serial #(
        .NTAPS(NTAPS), .W(W), .CW(CW), .COEFS(COEFS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in),
        .result_o(result_o), .valid_o(valid_o), .ovf_o(ovf_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int coef(input int i);
        return int'(COEFS[i*CW +: CW]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tap = {};
            for (int i = 0; i < NTAPS; i++) m_tap.push_back(0);
            m_ph = 0; e_res = 0; e_val = 0; e_ovf = 0; frames = 0;
        end else begin
            int sum;
            if (m_ph == 0) begin
                m_tap.push_front(int'(data_in));
                void'(m_tap.pop_back());
            end
            if (m_ph == W - 1) begin
                sum = 0;
                for (int i = 0; i < NTAPS; i++) sum += coef(i) * m_tap[i];
                e_res = sum % (1 << W);
                e_val = 1;
                if (sum >= (1 << W)) e_ovf = 1;
                frames++;
            end else begin
                e_val = 0;
            end
            m_ph = (m_ph + 1) % W;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        string rtag;
        if (!rst_n) return;
        if (frames == 0) rtag = "R1";
        else if (e_val == 0) rtag = "R5";
        else rtag = sect;
        chk("R3 valid", int'(valid_o), e_val);
        chk({rtag, " result"}, int'(result_o), e_res);
        chk(e_ovf != 0 ? "R7 overflow" : "R6 overflow", int'(ovf_o), e_ovf);
    endtask

    // One frame: sample at the load edge, optional noise elsewhere
    task automatic run_frame(input int sample, input bit noise);
        for (int c = 0; c < W; c++) begin
            @(negedge clk);
            compare();
            if (m_ph == 0) data_in = W'(sample);
            else data_in = noise ? W'($urandom_range(0, (1 << W) - 1)) : W'(sample);
        end
    endtask

    task automatic do_reset(input int cycles);
        rst_n = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            chk("R1 valid in reset", int'(valid_o), 0);
            chk("R1 result in reset", int'(result_o), 0);
            chk("R1 overflow in reset", int'(ovf_o), 0);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset(3);
        // R8: empty taps read zero after reset
        sect = "R8";
        run_frame(5, 0); run_frame(9, 0); run_frame(3, 0); run_frame(17, 0);
        // R4: random non-overflowing samples
        sect = "R4";
        for (int f = 0; f < 20; f++) run_frame($urandom_range(0, 127), 0);
        // R2: mid-frame noise on data_in must not matter
        sect = "R2";
        for (int f = 0; f < 10; f++) run_frame($urandom_range(0, 127), 1);
        // R6: exact boundary 255, then 257
        sect = "R6";
        run_frame(100, 0); run_frame(7, 0); run_frame(9, 0);
        run_frame(155, 1); run_frame(250, 1); run_frame(1, 0);
        // R7: sticky overflow across further frames
        sect = "R7";
        for (int f = 0; f < 10; f++) run_frame($urandom_range(0, 100), 1);
        // Mid-frame reset, then R8 again
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            compare();
        end
        do_reset(2);
        sect = "R8";
        run_frame(200, 1); run_frame(0, 1); run_frame(0, 0); run_frame(0, 0);
        run_frame(0, 0);
        @(negedge clk);
        compare();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule